// File: doc/BRIEF.md
# Row-Multiplexed 16x16 Glyph Matrix Scanner

The block drives a 16x16 LED dot matrix. Only one row is lit at a time. It steps through the rows quickly enough that the whole character appears at once. The glyph for each row comes from an internal table of 16 characters, each 16 rows by 16 columns. The table holds placeholder bitmaps that are computed from the character and row numbers.

Row scanning is paced by an internal prescaler on the system clock. Character sequencing advances only on a single-cycle `char_step` enable, which another part of the chip produces at a much slower rate. The `grp_sel` input chooses between two disjoint groups of characters:
- a short group of indices 0 to 3;
- a long group of indices 4 to 15.

A two-state sequencer tracks the group that the current index belongs to:
- `SEQ_LOW`: the index lies in 0..3.
- `SEQ_HIGH`: the index lies in 4..15.

On each `char_step` the sequencer takes one of four transitions:
- `ADV_LOW` (SEQ_LOW to SEQ_LOW, `grp_sel`=0): the index steps up and wraps 3 to 0.
- `ENTER_HIGH` (SEQ_LOW to SEQ_HIGH, `grp_sel`=1): the index loads 4.
- `ADV_HIGH` (SEQ_HIGH to SEQ_HIGH, `grp_sel`=1): the index steps up and wraps 15 to 4.
- `ENTER_LOW` (SEQ_HIGH to SEQ_LOW, `grp_sel`=0): the index loads 0.

Without a step, the state and the index hold.

Top module: `gms_top`

## Requirements
- R1: During reset `row_drv_n` is all ones and `col_data` is zero. The row index and the character index both reset to 0.
- R2: `row_drv_n` is one-hot active low: for row index r, only bit r is 0. The first row drive (row 0) appears on the first clock edge after reset is released.
- R3: `col_data` is the glyph of character c at row r, laid out as {c[3:0], r[3:0], c^r, ~r}, with c in bits 15:12 and ~r in bits 3:0. It is registered in the same clock edge as the row drive it belongs to.
- R4: The row index changes once every ROW_DIV (default 5) clock cycles. Row 0 is shown for the first 5 cycles after reset, then row 15.
- R5: The row index counts downward and wraps from 0 to 15.
- R6: With `grp_sel`=0 and the index inside 0..3, each `char_step` advances the index 0, 1, 2, 3, 0.
- R7: With `grp_sel`=1 and the index inside 4..15, each `char_step` advances the index by one, and 15 wraps to 4.
- R8: When `grp_sel` names the other group, the next `char_step` loads that group's first index (0 or 4).
- R9: Without `char_step` the character index does not change, so the character field of `col_data` holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| char_step | input | 1 | Single-cycle enable that advances the character |
| grp_sel | input | 1 | Group select: 0 for characters 0..3, 1 for characters 4..15 |
| row_drv_n | output | 16 | One-hot active-low row drive |
| col_data | output | 16 | Column data for the driven row |

## Verification
The assertions check on every cycle that:
- at most one row is driven;
- the row advances only after exactly ROW_DIV cycles and moves downward;
- a step in either group leaves the index inside that group;
- the index is held when there is no step.

Only the bench scenarios can show the exact order of characters. This covers the 3-to-0 and 15-to-4 wraps and the jump to a group's start after `grp_sel` changes. The bench also compares the absolute row against the cycle count since reset.

// File: rtl/gms_pkg.sv
package gms_pkg;
    localparam int ROW_N = 16;
    localparam int ROW_W = $clog2(ROW_N);
    localparam int CHR_N = 16;
    localparam int CHR_W = $clog2(CHR_N);
    localparam int COL_W = 16;

    typedef enum logic [0:0] {
        SEQ_LOW  = 1'b0,
        SEQ_HIGH = 1'b1
    } seq_state_t;

    // placeholder bitmap: character, row, their xor, inverted row
    function automatic logic [COL_W-1:0] glyph_bits(input logic [CHR_W-1:0] c,
                                                    input logic [ROW_W-1:0] r);
        return {c, r, c ^ r, ~r};
    endfunction
endpackage

// File: rtl/gms_row_scan.sv
module gms_row_scan #(
    parameter int ROW_DIV = 5,
    parameter int ROW_W   = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [ROW_W-1:0] row_idx
);
    localparam int CNT_W = (ROW_DIV > 2) ? $clog2(ROW_DIV) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(ROW_DIV - 1);

    logic [CNT_W-1:0] div_cnt;
    logic             row_step;

    assign row_step = (div_cnt == CNT_LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_cnt <= '0;
            row_idx <= '0;
        end else begin
            div_cnt <= row_step ? '0 : div_cnt + 1'b1;
            if (row_step) begin
                row_idx <= row_idx - 1'b1;   // wraps 0 -> all ones
            end
        end
    end
endmodule

// File: rtl/gms_char_seq.sv
module gms_char_seq
    import gms_pkg::*;
#(
    parameter int CHR_W    = 4,
    parameter int LO_FIRST = 0,
    parameter int LO_LAST  = 3,
    parameter int HI_FIRST = 4,
    parameter int HI_LAST  = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             char_step,
    input  logic             grp_sel,
    output logic [CHR_W-1:0] char_idx
);
    localparam logic [CHR_W-1:0] LO_A = CHR_W'(LO_FIRST);
    localparam logic [CHR_W-1:0] LO_Z = CHR_W'(LO_LAST);
    localparam logic [CHR_W-1:0] HI_A = CHR_W'(HI_FIRST);
    localparam logic [CHR_W-1:0] HI_Z = CHR_W'(HI_LAST);

    seq_state_t       state, state_nx;
    logic [CHR_W-1:0] idx_nx;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= SEQ_LOW;
            char_idx <= LO_A;
        end else if (char_step) begin
            state    <= state_nx;
            char_idx <= idx_nx;
        end
    end

    // next state and next index
    always_comb begin
        state_nx = state;
        idx_nx   = char_idx;
        unique case (state)
            SEQ_LOW: begin
                if (grp_sel) begin                 // ENTER_HIGH
                    state_nx = SEQ_HIGH;
                    idx_nx   = HI_A;
                end else begin                     // ADV_LOW
                    idx_nx = (char_idx == LO_Z) ? LO_A : char_idx + 1'b1;
                end
            end
            SEQ_HIGH: begin
                if (!grp_sel) begin                // ENTER_LOW
                    state_nx = SEQ_LOW;
                    idx_nx   = LO_A;
                end else begin                     // ADV_HIGH
                    idx_nx = (char_idx == HI_Z) ? HI_A : char_idx + 1'b1;
                end
            end
        endcase
    end
endmodule

// File: rtl/gms_row_decode.sv
module gms_row_decode #(
    parameter int ROW_N = 16,
    parameter int ROW_W = 4
) (
    input  logic [ROW_W-1:0] row_idx,
    output logic [ROW_N-1:0] row_n
);
    for (genvar i = 0; i < ROW_N; i++) begin : g_row
        assign row_n[i] = (row_idx != ROW_W'(i));
    end
endmodule

// File: rtl/gms_top.sv
module gms_top
    import gms_pkg::*;
#(
    parameter int ROW_DIV = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             char_step,
    input  logic             grp_sel,
    output logic [ROW_N-1:0] row_drv_n,
    output logic [COL_W-1:0] col_data
);
    logic [ROW_W-1:0] row_idx;
    logic [CHR_W-1:0] char_idx;
    logic [ROW_N-1:0] row_dec_n;

    gms_row_scan #(.ROW_DIV(ROW_DIV), .ROW_W(ROW_W)) u_scan (
        .clk     (clk),
        .rst_n   (rst_n),
        .row_idx (row_idx)
    );

    gms_char_seq #(.CHR_W(CHR_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .char_step (char_step),
        .grp_sel   (grp_sel),
        .char_idx  (char_idx)
    );

    gms_row_decode #(.ROW_N(ROW_N), .ROW_W(ROW_W)) u_dec (
        .row_idx (row_idx),
        .row_n   (row_dec_n)
    );

    // row drive and its column data leave in the same register stage
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            row_drv_n <= '1;
            col_data  <= '0;
        end else begin
            row_drv_n <= row_dec_n;
            col_data  <= glyph_bits(char_idx, row_idx);
        end
    end
endmodule

// File: rtl/gms_checker.sv
module gms_checker #(
    parameter int ROW_DIV = 5
) (
    input logic        clk,
    input logic        rst_n,
    input logic        char_step,
    input logic        grp_sel,
    input logic [15:0] row_drv_n,
    input logic [3:0]  char_idx
);
    logic        started;
    logic [15:0] row_prev;
    logic [7:0]  gap;
    logic        row_moved;

    assign row_moved = (row_drv_n != row_prev);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            started  <= 1'b0;
            row_prev <= '1;
            gap      <= '0;
        end else begin
            row_prev <= row_drv_n;
            gap      <= row_moved ? 8'd0 : gap + 8'd1;
            if (row_moved) started <= 1'b1;
        end
    end

    a_r2_single_row: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~row_drv_n));

    a_r4_row_period: assert property (@(posedge clk) disable iff (!rst_n)
        (started && row_moved) |-> (gap == 8'(ROW_DIV - 1)));

    a_r5_row_down: assert property (@(posedge clk) disable iff (!rst_n)
        (started && row_moved) |-> (row_drv_n == {row_prev[0], row_prev[15:1]}));

    a_r6_low_range: assert property (@(posedge clk) disable iff (!rst_n)
        (char_step && !grp_sel) |=> (char_idx < 4'd4));

    a_r7_high_range: assert property (@(posedge clk) disable iff (!rst_n)
        (char_step && grp_sel) |=> (char_idx >= 4'd4));

    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !char_step |=> $stable(char_idx));
endmodule

bind gms_top gms_checker #(.ROW_DIV(ROW_DIV)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .char_step (char_step),
    .grp_sel   (grp_sel),
    .row_drv_n (row_drv_n),
    .char_idx  (char_idx)
);

// File: tb/gms_top_tb.sv
`timescale 1ns/1ps
module gms_top_tb;
    localparam int DIV = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        char_step = 1'b0;
    logic        grp_sel = 1'b0;
    logic [15:0] row_drv_n;
    logic [15:0] col_data;

    int n_chk = 0;
    int n_bad = 0;
    int edges = 0;
    bit live_chk = 1'b0;
    bit done = 1'b0;
    logic [3:0] model_c = 4'd0;

    always #2 clk = ~clk;

    gms_top #(.ROW_DIV(DIV)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .char_step (char_step),
        .grp_sel   (grp_sel),
        .row_drv_n (row_drv_n),
        .col_data  (col_data)
    );

    always @(posedge clk) if (rst_n) edges <= edges + 1;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // per-cycle row and column coherence
    always @(negedge clk) begin
        if (live_chk && edges > 0) begin
            int r;
            r = (16 - (((edges - 1) / DIV) % 16)) % 16;
            check("R2/R4/R5 row drive", row_drv_n, ~(32'd1 << r) & 32'hFFFF);
            check("R3 column coherence", {col_data[11:8], col_data[7:4], col_data[3:0]},
                  {4'(r), col_data[15:12] ^ 4'(r), ~4'(r)});
        end
    end

    function automatic logic [3:0] next_c(input logic [3:0] c, input logic g);
        if (g) return (c >= 4'd4 && c < 4'd15) ? c + 4'd1 : 4'd4;
        return (c < 4'd3) ? c + 4'd1 : 4'd0;
    endfunction

    task automatic step(input string req);
        @(negedge clk) char_step = 1'b1;
        @(negedge clk) char_step = 1'b0;
        model_c = next_c(model_c, grp_sel);
        repeat (2) @(negedge clk);
        check(req, col_data[15:12], model_c);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset row", row_drv_n, 16'hFFFF);
        check("R1 reset col", col_data, 16'h0000);
        rst_n = 1'b1;
        live_chk = 1'b1;
        @(negedge clk);
        check("R1 first char", col_data[15:12], 4'd0);
        check("R3 first glyph", col_data, {4'd0, 4'd0, 4'd0, 4'hF});
        // R4 R5: two full row sweeps checked per cycle
        repeat (2 * 16 * DIV) @(negedge clk);
        // R6: low group sweep through the 3 -> 0 wrap
        for (int i = 0; i < 6; i++) step("R6 low group sequence");
        // R8: switch to high group
        grp_sel = 1'b1;
        step("R8 enter high group at 4");
        // R7: high group through the 15 -> 4 wrap
        for (int i = 0; i < 14; i++) step("R7 high group sequence");
        // R9: hold without steps
        for (int i = 0; i < 5; i++) begin
            repeat (23) @(negedge clk);
            check("R9 character hold", col_data[15:12], model_c);
        end
        // R8: back to low group
        grp_sel = 1'b0;
        step("R8 enter low group at 0");
        step("R6 low after return");
        grp_sel = 1'b1;
        step("R8 re-enter high");
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (200000) @(posedge clk);
                n_chk++;
                n_bad++;
                $display("FAIL watchdog actual=hung expected=done");
            end
        join_any
        live_chk = 1'b0;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule